// File: doc/BRIEF.md
# Breakpoint Extended Value Register Bank

This block stores one 32-bit extension word for each of up to sixteen hardware breakpoints. The word widens a breakpoint's match condition. Depending on that breakpoint's type code, the word holds either a virtual machine identifier or a second context identifier. A single 4-bit index selects the register for both writing and reading. Writes are taken on the clock edge. Read data is combinational and already masked for the selected breakpoint's current type code.

Configuration straps set the following:
- how many breakpoints exist;
- which breakpoints can match on context;
- whether a hypervisor level exists;
- the VMID width controls;
- whether the host extension exists.

From these the block works out whether each index is backed by a register. It reports this on an allocated flag for the indexed register.

The bank has two reset inputs. Cold reset clears the stored words. Warm reset has no effect on the block at all. The comparators that use these words, and the access permission checks, live outside this block.

Top module: `bkpt_xval_bank`

## Requirements
- R1: An index is allocated only when all of these hold: the index is at most `cfg_bp_last`, bit `cfg_ctx_mask[index]` is 1, and `cfg_hyp_present` is 1. `idx_alloc` reports this for `acc_idx`.
- R2: While `acc_idx` is unallocated, `rd_data` reads zero and `idx_alloc` is low. A write to an unallocated index is dropped, so a later read after the index becomes allocated shows the earlier value.
- R3: When bits [3:2] of the indexed type code are 2'b10, the word is a VMID. Bits [31:16] read zero, and bits [7:0] read the stored low byte.
- R4: In VMID mode, bits [15:8] show the stored upper byte only when `cfg_vmid16`=1, `cfg_vmid_size`=1 and `cfg_hyp_32bit`=0. Otherwise those bits read zero.
- R5: When bits [3:2] of the type code are 2'b11, all 32 stored bits are returned if `cfg_host_ext`=1. If `cfg_host_ext`=0, the word reads zero.
- R6: When bit 3 of the type code is 0, the word reads zero.
- R7: All 32 written bits are kept, and the masking follows the type code at read time. Changing the type code changes the read-back without a new write.
- R8: Cold reset (active low, asynchronous) clears every stored word to zero. Asserting `warm_rst_n` low leaves every stored word unchanged.
- R9: A write (`wr_en`=1 at a rising edge) is visible on `rd_data` right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low; does not affect the bank |
| wr_en | input | 1 | Write strobe |
| acc_idx | input | 4 | Register index for write and read |
| wr_data | input | 32 | Write data |
| bp_type | input | NUM_BP*4 | Type code of each breakpoint, 4 bits each, breakpoint i at [4i+3:4i] |
| cfg_bp_last | input | 4 | Highest implemented breakpoint index |
| cfg_ctx_mask | input | NUM_BP | Per-breakpoint context-match capability |
| cfg_hyp_present | input | 1 | Hypervisor level exists |
| cfg_vmid16 | input | 1 | Implementation has a 16-bit VMID |
| cfg_vmid_size | input | 1 | Stage-2 VMID size control |
| cfg_hyp_32bit | input | 1 | Hypervisor runs in 32-bit state |
| cfg_host_ext | input | 1 | Host extension exists |
| rd_data | output | 32 | Masked read data for `acc_idx` |
| idx_alloc | output | 1 | `acc_idx` is allocated |

## Verification
The assertions assume three things about the inputs:
- `wr_en`, `acc_idx`, the type codes and the straps are driven to known values from the first cycle after cold reset.
- `wr_en` stays low while cold reset is held.
- The straps change only between accesses, never in the cycle of a write they could affect.

The bench drives every input on the falling edge. It holds `wr_en` low through reset and during all strap and type changes. It changes one control at a time, then samples the combinational read path before the next rising edge.

// File: rtl/bkpt_xval_bank.sv
module bkpt_xval_bank #(
  parameter int NUM_BP = 16,
  parameter int DW     = 32
) (
  input  logic                clk,
  input  logic                cold_rst_n,
  input  logic                warm_rst_n,
  input  logic                wr_en,
  input  logic [3:0]          acc_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic [NUM_BP*4-1:0] bp_type,
  input  logic [3:0]          cfg_bp_last,
  input  logic [NUM_BP-1:0]   cfg_ctx_mask,
  input  logic                cfg_hyp_present,
  input  logic                cfg_vmid16,
  input  logic                cfg_vmid_size,
  input  logic                cfg_hyp_32bit,
  input  logic                cfg_host_ext,
  output logic [DW-1:0]       rd_data,
  output logic                idx_alloc
);
  localparam int IDX_W = 4;
  localparam int VLO   = 8;
  localparam int VHI   = 16;

  logic [DW-1:0] word [NUM_BP];
  logic [3:0]    ty   [NUM_BP];
  logic          in_range;
  logic [DW-1:0] sel_word;
  logic [3:0]    sel_ty;
  logic          vmid_wide;

  assign in_range  = int'(acc_idx) < NUM_BP;
  assign idx_alloc = in_range && (acc_idx <= cfg_bp_last) &&
                     cfg_ctx_mask[acc_idx] && cfg_hyp_present;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_reg
    assign ty[i] = bp_type[i*4 +: 4];
    always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)
        word[i] <= '0;
      else if (wr_en && idx_alloc && acc_idx == IDX_W'(i))
        word[i] <= wr_data;
    end
  end

  assign sel_word  = in_range ? word[acc_idx] : '0;
  assign sel_ty    = in_range ? ty[acc_idx]   : 4'b0000;
  assign vmid_wide = cfg_vmid16 && cfg_vmid_size && !cfg_hyp_32bit;

  always_comb begin
    rd_data = '0;
    if (idx_alloc) begin
      unique case (sel_ty[3:2])
        2'b10: begin
          rd_data[VLO-1:0] = sel_word[VLO-1:0];
          if (vmid_wide) rd_data[VHI-1:VLO] = sel_word[VHI-1:VLO];
        end
        2'b11:   if (cfg_host_ext) rd_data = sel_word;
        default: rd_data = '0;
      endcase
    end
  end

  a_r2_unalloc_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !idx_alloc |-> rd_data == '0);

  a_r3_vmid_top_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (sel_ty[3:2] == 2'b10) |-> rd_data[DW-1:VHI] == '0);

  a_r4_narrow_vmid: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((sel_ty[3:2] == 2'b10) && (!cfg_vmid16 || !cfg_vmid_size || cfg_hyp_32bit))
      |-> rd_data[VHI-1:VLO] == '0);

  a_r5_no_host_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((sel_ty[3:2] == 2'b11) && !cfg_host_ext) |-> rd_data == '0);

  a_r6_other_type_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sel_ty[3] |-> rd_data == '0);

  a_r8_warm_keeps: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst_n && !$past(wr_en) && $stable(acc_idx) && $stable(bp_type) &&
     $stable(cfg_bp_last) && $stable(cfg_ctx_mask) && $stable(cfg_hyp_present) &&
     $stable(cfg_vmid16) && $stable(cfg_vmid_size) && $stable(cfg_hyp_32bit) &&
     $stable(cfg_host_ext)) |-> $stable(rd_data));

  a_r9_write_visible: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ($past(wr_en && idx_alloc) && $stable(acc_idx) && idx_alloc &&
     (sel_ty[3:2] == 2'b11) && cfg_host_ext) |-> rd_data == $past(wr_data));
endmodule

// File: tb/bkpt_xval_bank_tb.sv
module bkpt_xval_bank_tb;
  logic        clk = 0;
  logic        cold_rst_n = 0, warm_rst_n = 1;
  logic        wr_en = 0;
  logic [3:0]  acc_idx = 0;
  logic [31:0] wr_data = 0;
  logic [63:0] bp_type = '0;
  logic [3:0]  cfg_bp_last = 4'd15;
  logic [15:0] cfg_ctx_mask = 16'hFFFF;
  logic        cfg_hyp_present = 1, cfg_vmid16 = 1, cfg_vmid_size = 1;
  logic        cfg_hyp_32bit = 0, cfg_host_ext = 1;
  logic [31:0] rd_data;
  logic        idx_alloc;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bkpt_xval_bank u_dut (
    .clk, .cold_rst_n, .warm_rst_n, .wr_en, .acc_idx, .wr_data, .bp_type,
    .cfg_bp_last, .cfg_ctx_mask, .cfg_hyp_present, .cfg_vmid16, .cfg_vmid_size,
    .cfg_hyp_32bit, .cfg_host_ext, .rd_data, .idx_alloc);

  task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ty(int i, logic [3:0] t);
    @(negedge clk); bp_type[i*4 +: 4] = t;
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] d);
    @(negedge clk); acc_idx = i; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] i, logic al, logic [31:0] exp);
    @(negedge clk); acc_idx = i; #1;
    chk(req, {idx_alloc, rd_data}, {al, exp});
  endtask

  task automatic t_reset;
    set_ty(0, 4'b1100); set_ty(5, 4'b1111);
    rd_chk("R8 cold reset clear", 0, 1, 0);
    rd_chk("R8 cold reset clear", 5, 1, 0);
  endtask

  task automatic t_alloc;
    @(negedge clk); cfg_bp_last = 4'd11; cfg_ctx_mask = 16'hF0FF;
    rd_chk("R1 allocated", 3, 1, 0);
    rd_chk("R1 no ctx capability", 9, 0, 0);
    rd_chk("R1 beyond last", 13, 0, 0);
    @(negedge clk); cfg_hyp_present = 0;
    rd_chk("R1 no hypervisor", 3, 0, 0);
    @(negedge clk); cfg_hyp_present = 1;
  endtask

  task automatic t_unalloc_write;
    set_ty(9, 4'b1100);
    wr(9, 32'hA5A5_5A5A);
    rd_chk("R2 unallocated read", 9, 0, 0);
    @(negedge clk); cfg_ctx_mask[9] = 1;
    rd_chk("R2 write dropped", 9, 1, 0);
  endtask

  task automatic t_vmid;
    set_ty(2, 4'b1000);
    wr(2, 32'hDEAD_BEEF);
    rd_chk("R3 R4 wide VMID", 2, 1, 32'h0000_BEEF);
    @(negedge clk); cfg_vmid_size = 0;
    rd_chk("R4 size control 0", 2, 1, 32'h0000_00EF);
    @(negedge clk); cfg_vmid_size = 1; cfg_hyp_32bit = 1;
    rd_chk("R4 hyp 32-bit", 2, 1, 32'h0000_00EF);
    @(negedge clk); cfg_hyp_32bit = 0; cfg_vmid16 = 0;
    rd_chk("R4 8-bit VMID", 2, 1, 32'h0000_00EF);
    @(negedge clk); cfg_vmid16 = 1;
  endtask

  task automatic t_ctx2;
    set_ty(4, 4'b1101);
    wr(4, 32'h1234_5678);
    rd_chk("R5 context id", 4, 1, 32'h1234_5678);
    @(negedge clk); cfg_host_ext = 0;
    rd_chk("R5 no host ext", 4, 1, 0);
    @(negedge clk); cfg_host_ext = 1;
  endtask

  task automatic t_other;
    set_ty(4, 4'b0101);
    rd_chk("R6 type 01xx", 4, 1, 0);
    set_ty(4, 4'b0011);
    rd_chk("R6 type 00xx", 4, 1, 0);
  endtask

  task automatic t_retype;
    set_ty(2, 4'b1110);
    rd_chk("R7 retype to context", 2, 1, 32'hDEAD_BEEF);
    set_ty(2, 4'b1011);
    rd_chk("R7 retype to VMID", 2, 1, 32'h0000_BEEF);
  endtask

  task automatic t_timing;
    set_ty(6, 4'b1100);
    @(negedge clk); acc_idx = 6; wr_data = 32'hCAFE_0001; wr_en = 1; #1;
    chk("R9 before edge", {1'b0, rd_data}, 33'h0);
    @(posedge clk); #1;
    chk("R9 after edge", {1'b0, rd_data}, {1'b0, 32'hCAFE_0001});
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_warm_cold;
    @(negedge clk); warm_rst_n = 0;
    repeat (3) @(negedge clk);
    rd_chk("R8 warm reset held", 6, 1, 32'hCAFE_0001);
    @(negedge clk); warm_rst_n = 1;
    rd_chk("R8 warm reset no effect", 4, 1, 0);
    set_ty(4, 4'b1100);
    rd_chk("R8 warm reset no effect", 4, 1, 32'h1234_5678);
    @(negedge clk); cold_rst_n = 0;
    @(negedge clk); cold_rst_n = 1;
    rd_chk("R8 cold reset clears", 6, 1, 0);
    rd_chk("R8 cold reset clears", 4, 1, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        cold_rst_n = 1;
        t_reset(); t_alloc(); t_unalloc_write(); t_vmid(); t_ctx2();
        t_other(); t_retype(); t_timing(); t_warm_cold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule